// File: doc/BRIEF.md
# Systolic Lookahead String Matcher

This block finds, for every candidate start position in a sliding window, how far a short stored search string (the lookahead) matches the window text from that position. Each element of a linear array keeps one lookahead symbol. Window symbols enter at the first element and move one element further per clock through a chain of delay registers. Each element compares its stored symbol with the symbol passing it and registers an equality flag.

Per-element delay lines realign the flags that belong to one candidate start. A length encoder then counts the unbroken run of matches beginning at the first lookahead slot, and that count is registered as the match length. A match tracker further up the chain consumes one length and one position index per clock. Picking the best match and forming codewords happen outside this block.

A scan starts when `start` is high. The window symbol with index 0 is presented in that same cycle, and one further symbol follows on every later clock. A scan of WIN_LEN candidates reads WIN_LEN+LA_LEN-1 symbols.

Top module: `lahead_match_array`

## Requirements
- R1: After synchronous reset, `len_valid` is 0, `len_out` is 0 and `pos_out` is 0.
- R2: When `la_wr` is high at a rising edge, lookahead slot `la_addr` takes `la_data`. Slot 0 is compared with the candidate's first symbol, and slot k with the symbol k places later. The new value applies to every comparison made after that edge.
- R3: If `start` is sampled at edge T, `len_valid` is high after edges T+2·LA_LEN through T+2·LA_LEN+WIN_LEN-1 and low after every other edge, so a scan gives exactly WIN_LEN results.
- R4: The result after edge T+2·LA_LEN+p carries `pos_out` = p, so positions run 0 to WIN_LEN-1 on consecutive cycles.
- R5: For candidate p, `len_out` is the number of consecutive slots k, counting up from slot 0, with slot k equal to window symbol p+k. A mismatch at slot 0 gives 0.
- R6: A candidate whose LA_LEN symbols all match gives `len_out` = LA_LEN, which is the largest value the output can take.
- R7: A `start` during a running scan abandons that scan. No further result of the old scan appears, and timing and positions restart as in R3 and R4 from the new `start`.
- R8: A lookahead write in the same cycle as `start` is already in effect for candidate 0 of the scan begun by that `start`.
- R9: While `len_valid` is low, `len_out` and `pos_out` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| la_wr | input | 1 | Lookahead slot write strobe |
| la_addr | input | AW | Slot index for the write |
| la_data | input | SYM_W | Symbol to store |
| start | input | 1 | Begin a scan; window symbol 0 is presented in this cycle |
| sym_in | input | SYM_W | Window symbol stream, one per clock |
| len_valid | output | 1 | A candidate result is present |
| len_out | output | LW | Match length of the candidate |
| pos_out | output | PW | Candidate start position within the scan |

## Verification
Two events can land on the same clock edge. A lookahead write can coincide with `start`, and a new `start` can arrive while results of the previous scan are still being reported. The bench provokes the first by changing slot 0 at the start cycle. It then requires candidate 0 to be scored against the new symbol. It provokes the second by cutting a scan short after a few results and restarting at once with fresh text. It then requires that `len_valid` drops at the restart edge and that the next result is position 0 of the new text, exactly 2·LA_LEN edges later.

// File: rtl/lzm_pkg.sv
package lzm_pkg;

  // Length of the unbroken run of ones from bit 0 upward, over n bits.
  function automatic int lead_ones(input logic [31:0] v, input int n);
    int  run;
    bit  stop;
    run  = 0;
    stop = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) begin
        if (!stop && v[i]) run++;
        else stop = 1'b1;
      end
    end
    return run;
  endfunction

endpackage

// File: rtl/lzm_pe.sv
module lzm_pe #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             y_we,
  input  logic [SYM_W-1:0] y_din,
  input  logic [SYM_W-1:0] x_cur,
  output logic             eq_flag
);

  logic [SYM_W-1:0] y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q     <= '0;
      eq_flag <= 1'b0;
    end else begin
      if (y_we) y_q <= y_din;
      eq_flag <= (x_cur == y_q);
    end
  end

  // R2: a write lands in the slot register on the next edge
  a_r2_slot_write: assert property (@(posedge clk) disable iff (rst)
    y_we |=> (y_q == $past(y_din)));

endmodule

// File: rtl/lzm_skew.sv
module lzm_skew #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_line
      logic [DEPTH-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[DEPTH-2 >= 0 ? DEPTH-2 : 0 : 0] & {(DEPTH > 1 ? DEPTH-1 : 1){DEPTH > 1}}, d} & {DEPTH{1'b1}};
      end
      assign q = sh[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/lzm_len_enc.sv
module lzm_len_enc
  import lzm_pkg::*;
#(
  parameter int N  = 4,
  parameter int LW = 3
) (
  input  logic [N-1:0]  flags,
  output logic [LW-1:0] run_len
);

  always_comb begin
    run_len = LW'(lead_ones(32'(flags), N));
  end

endmodule

// File: rtl/lahead_match_array.sv
module lahead_match_array #(
  parameter int LA_LEN  = 4,
  parameter int SYM_W   = 8,
  parameter int WIN_LEN = 12,
  localparam int AW = (LA_LEN > 1) ? $clog2(LA_LEN) : 1,
  localparam int LW = $clog2(LA_LEN + 1),
  localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             la_wr,
  input  logic [AW-1:0]    la_addr,
  input  logic [SYM_W-1:0] la_data,
  input  logic             start,
  input  logic [SYM_W-1:0] sym_in,
  output logic             len_valid,
  output logic [LW-1:0]    len_out,
  output logic [PW-1:0]    pos_out
);

  localparam int FILL = 2 * LA_LEN;
  localparam int LAST = FILL + WIN_LEN - 1;
  localparam int CW   = $clog2(LAST + 2);
  localparam logic [CW-1:0] FILL_C = CW'(FILL);
  localparam logic [CW-1:0] LAST_C = CW'(LAST);

  // Window symbol chain: stage j holds the symbol that entered j+1 edges ago
  logic [SYM_W-1:0] x_pipe [LA_LEN];
  logic [LA_LEN-1:0] eq_raw;
  logic [LA_LEN-1:0] eq_aln;
  logic [LW-1:0]     run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < LA_LEN; j++) x_pipe[j] <= '0;
    end else begin
      x_pipe[0] <= sym_in;
      for (int j = 1; j < LA_LEN; j++) x_pipe[j] <= x_pipe[j-1];
    end
  end

  generate
    for (genvar j = 0; j < LA_LEN; j++) begin : g_cell
      lzm_pe #(.SYM_W(SYM_W)) u_pe (
        .clk     (clk),
        .rst     (rst),
        .y_we    (la_wr && (la_addr == AW'(j))),
        .y_din   (la_data),
        .x_cur   (x_pipe[j]),
        .eq_flag (eq_raw[j])
      );
      // Flag of slot j leads the last slot by 2*(LA_LEN-1-j) edges
      lzm_skew #(.DEPTH(2 * (LA_LEN - 1 - j))) u_skew (
        .clk (clk),
        .rst (rst),
        .d   (eq_raw[j]),
        .q   (eq_aln[j])
      );
    end
  endgenerate

  lzm_len_enc #(.N(LA_LEN), .LW(LW)) u_enc (
    .flags   (eq_aln),
    .run_len (run_len)
  );

  // Scan sequencing and registered results
  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      len_valid <= 1'b0;
      len_out   <= '0;
      pos_out   <= '0;
    end else begin
      len_valid <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(1);
      end else if (busy) begin
        cnt <= cnt + CW'(1);
        if (cnt >= FILL_C) begin
          len_valid <= 1'b1;
          len_out   <= run_len;
          pos_out   <= PW'(cnt - FILL_C);
        end
        if (cnt == LAST_C) busy <= 1'b0;
      end
    end
  end

  // Checking aids: results seen since the last start
  logic [PW:0] seen;
  always_ff @(posedge clk) begin
    if (rst || start) seen <= '0;
    else if (len_valid) seen <= seen + (PW+1)'(1);
  end

  a_r3_result_count: assert property (@(posedge clk) disable iff (rst)
    len_valid |-> (seen < (PW+1)'(WIN_LEN)));

  a_r4_pos_first: assert property (@(posedge clk) disable iff (rst)
    $rose(len_valid) |-> (pos_out == '0));

  a_r4_pos_step: assert property (@(posedge clk) disable iff (rst)
    (len_valid && $past(len_valid)) |-> (pos_out == PW'($past(pos_out) + 1'b1)));

  a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
    len_out <= LW'(LA_LEN));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !len_valid |-> ($stable(len_out) && $stable(pos_out)));

  a_r7_restart_kill: assert property (@(posedge clk) disable iff (rst)
    start |=> !len_valid);

endmodule

// File: tb/lahead_match_array_tb.sv
module lahead_match_array_tb;

  localparam int LA  = 4;
  localparam int SW  = 8;
  localparam int WIN = 12;
  localparam int AW  = 2;
  localparam int LW  = 3;
  localparam int PW  = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          la_wr;
  logic [AW-1:0] la_addr;
  logic [SW-1:0] la_data;
  logic          start;
  logic [SW-1:0] sym_in;
  logic          len_valid;
  logic [LW-1:0] len_out;
  logic [PW-1:0] pos_out;

  always #5 clk = ~clk;

  lahead_match_array #(.LA_LEN(LA), .SYM_W(SW), .WIN_LEN(WIN)) u_dut (
    .clk(clk), .rst(rst), .la_wr(la_wr), .la_addr(la_addr), .la_data(la_data),
    .start(start), .sym_in(sym_in), .len_valid(len_valid), .len_out(len_out),
    .pos_out(pos_out)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [SW-1:0] ys [LA];
  logic [SW-1:0] xs [32];
  int last_len = 0;
  int last_pos = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int p);
    int n = 0;
    for (int k = 0; k < LA; k++) begin
      if (ys[k] != xs[p+k]) break;
      n++;
    end
    return n;
  endfunction

  task automatic load_slot(input int slot, input logic [SW-1:0] v);
    @(negedge clk);
    la_wr = 1'b1; la_addr = AW'(slot); la_data = v;
    @(posedge clk); #1;
    la_wr = 1'b0;
    ys[slot] = v;
  endtask

  // Run (part of) a scan; optional slot write in the start cycle
  task automatic run_scan(input int ncyc, input bit do_ld, input int ld_slot,
                          input logic [SW-1:0] ld_val, input string llbl);
    if (do_ld) ys[ld_slot] = ld_val;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      start = (k == 0);
      la_wr = do_ld && (k == 0);
      la_addr = AW'(ld_slot); la_data = ld_val;
      sym_in = xs[k];
      @(posedge clk); #1;
      start = 1'b0; la_wr = 1'b0;
      if (k >= 2*LA && k < 2*LA + WIN) begin
        int p = k - 2*LA;
        int e = exp_len(p);
        check(len_valid === 1'b1, "R3", int'(len_valid), 1);
        check(int'(pos_out) == p, "R4", int'(pos_out), p);
        check(int'(len_out) == e, (e == LA) ? "R6" : llbl, int'(len_out), e);
        last_len = e; last_pos = p;
      end else begin
        check(len_valid === 1'b0, (k == 0) ? "R7" : "R3", int'(len_valid), 0);
        check(int'(len_out) == last_len && int'(pos_out) == last_pos, "R9",
              int'(len_out), last_len);
      end
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    string s;
    void'($urandom(32'd4242));
    rst = 1'b1; la_wr = 1'b0; la_addr = '0; la_data = '0; start = 1'b0; sym_in = '0;
    for (int i = 0; i < LA; i++) ys[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(len_valid === 1'b0, "R1", int'(len_valid), 0);
    check(len_out == '0, "R1", int'(len_out), 0);
    check(pos_out == '0, "R1", int'(pos_out), 0);
    @(negedge clk); rst = 1'b0;

    // Directed: full, partial and slot-0 mismatches
    load_slot(0, "A"); load_slot(1, "B"); load_slot(2, "C"); load_slot(3, "D");
    s = "ABCDABCABXAABCDAQ";
    for (int i = 0; i < 32; i++) xs[i] = (i < s.len()) ? s[i] : 8'h00;
    run_scan(2*LA + WIN + 3, 1'b0, 0, 8'h00, "R5");

    // R2: rewrite the last slot, scoring must follow it
    load_slot(3, "Q");
    run_scan(2*LA + WIN + 1, 1'b0, 0, 8'h00, "R2");

    // R8: slot 0 rewritten in the start cycle
    for (int i = 0; i < 32; i++) xs[i] = (i % 5 == 0) ? "Z" : "B";
    run_scan(2*LA + WIN + 1, 1'b1, 0, "Z", "R8");

    // R7: abort after three results, restart at once with new text
    for (int i = 0; i < 32; i++) xs[i] = SW'($urandom % 3);
    for (int i = 0; i < LA; i++) load_slot(i, SW'($urandom % 3));
    run_scan(2*LA + 3, 1'b0, 0, 8'h00, "R5");
    for (int i = 0; i < 32; i++) xs[i] = SW'($urandom % 2);
    run_scan(2*LA + WIN + 2, 1'b0, 0, 8'h00, "R7");

    // Random scans over a small alphabet
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < LA; i++) load_slot(i, SW'($urandom % 3));
      for (int i = 0; i < 32; i++) xs[i] = SW'($urandom % 3);
      if (r % 3 == 0)
        for (int i = 0; i < LA; i++) xs[(r % 7) + i] = ys[i];
      run_scan(2*LA + WIN + 2, 1'b0, 0, 8'h00, "R5");
    end

    // R9: idle after a scan, outputs held
    repeat (5) @(posedge clk);
    #1;
    check(len_valid === 1'b0, "R9", int'(len_valid), 0);
    check(int'(len_out) == last_len, "R9", int'(len_out), last_len);
    check(int'(pos_out) == last_pos, "R9", int'(pos_out), last_pos);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule